// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder into a position count held between two programmable limits. Each phase passes through a two-stage synchronizer, an optional per-phase inversion and an optional per-phase stability filter before it is decoded. In quadrature mode every legal Gray-code step of the phase pair moves the count by one, which gives four counts per encoder line. In pulse/direction mode a rising edge on phase A moves the count, and the level of phase B gives the direction.

The count stays inside the window from `lowLimit` to `highLimit`. A step above the upper bound reloads the lower bound, and a step below the lower bound reloads the upper bound. Each wrap raises a sticky overflow flag and records which end of the window caused it. A separate status bit shows the direction of the latest step, and a clear strobe moves the count back to the lower bound.

Top module: `qdec_position_counter`

## Requirements
- R1: After reset `count` is 0, and `dirUp`, `ovfFlag` and `ovfAtTop` are all 0.
- R2: With `modeCntDir`=0, each change of a single effective phase counts one step. The step is up when phase A leads, following the sequence (A,B) 00→10→11→01→00. The step is down for the reverse sequence.
- R3: With `modeCntDir`=0, a change of both effective phases in the same filtered sample is ignored and leaves `count` and `dirUp` unchanged.
- R4: With `modeCntDir`=1, a rising edge of effective phase A counts up when effective phase B is 1 and down when it is 0. A falling edge of A and any change of B do not count.
- R5: When `invA` or `invB` is 1, that phase is inverted before decoding. Toggling the inversion therefore acts as a transition of that phase.
- R6: When a phase's filter is enabled, a new level reaches the decoder only after it has been stable for `filtVal`+1 consecutive clocks. A shorter pulse is dropped. When the filter is disabled, the synchronized level passes on every clock.
- R7: A step up while `count` ≥ `highLimit` loads `lowLimit`, sets `ovfFlag` and sets `ovfAtTop` to 1.
- R8: A step down while `count` ≤ `lowLimit` loads `highLimit`, sets `ovfFlag` and sets `ovfAtTop` to 0.
- R9: `dirUp` is 1 after an up step and 0 after a down step. It holds its value between steps.
- R10: A one-clock `clearCnt` pulse loads `count` with `lowLimit`. It takes priority over a step in the same clock.
- R11: `ovfFlag` stays set until a one-clock `ovfClr` pulse. A wrap in the same clock as the pulse keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modeCntDir | input | 1 | 0 = quadrature decoding, 1 = pulse/direction decoding |
| phaseA | input | 1 | Raw encoder phase A |
| phaseB | input | 1 | Raw encoder phase B |
| invA | input | 1 | Invert phase A |
| invB | input | 1 | Invert phase B |
| filtEnA | input | 1 | Enable the stability filter on phase A |
| filtEnB | input | 1 | Enable the stability filter on phase B |
| filtValA | input | FILT_W | Stability length minus one for phase A |
| filtValB | input | FILT_W | Stability length minus one for phase B |
| lowLimit | input | CNT_W | Lower bound of the count window |
| highLimit | input | CNT_W | Upper bound of the count window |
| clearCnt | input | 1 | Load `count` with `lowLimit` |
| ovfClr | input | 1 | Clear the sticky overflow flag |
| count | output | CNT_W | Position count |
| dirUp | output | 1 | Direction of the latest step |
| ovfFlag | output | 1 | Sticky wrap flag |
| ovfAtTop | output | 1 | 1 = latest wrap at the upper bound, 0 = at the lower bound |

## Verification
The decoder is driven with a full forward Gray cycle and then the reverse cycle, so a swapped up/down decode or a dropped edge shows as a wrong count. Simultaneous double changes of the phases are then applied and must leave the count alone. Windows narrowed to a few counts make the decoder wrap at both ends, which separates the top and bottom reload values, the origin bit and the sticky behaviour of the flag around its clear pulse. Pulse/direction mode is tried with falling edges and B-only changes, which must not count. Toggling the inversion shows up as a single step. A phase-A pulse shorter than the filter window, followed by a level held longer than the window, shows that the filter drops glitches but passes real edges.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef struct packed {
    logic stepUp;
    logic stepDn;
    logic clear;
    logic ovfClr;
  } qdec_strobe_t;

  typedef enum logic {
    MODE_QUAD   = 1'b0,
    MODE_CNTDIR = 1'b1
  } qdec_mode_e;
endpackage

// File: rtl/qdec_phase_cond.sv
module qdec_phase_cond #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rawIn,
  input  logic              invert,
  input  logic              filtEn,
  input  logic [FILT_W-1:0] filtVal,
  output logic              filtOut
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   polIn;
  logic [FILT_W-1:0]      stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
  end

  assign polIn = syncQ[SYNC_STAGES-1] ^ invert;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtOut   <= 1'b0;
      stableCnt <= '0;
    end else if (!filtEn) begin
      filtOut   <= polIn;
      stableCnt <= '0;
    end else if (polIn == filtOut) begin
      stableCnt <= '0;
    end else if (stableCnt == filtVal) begin
      filtOut   <= polIn;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + 1'b1;
    end
  end

  // R6: with the filter off the conditioned level follows one clock later
  p_filter_bypass_r6: assert property (@(posedge clk) disable iff (!rstN)
    !filtEn |=> filtOut == $past(polIn));

  // R6: with the filter on and a nonzero window, a level change needs the new level seen on the previous clock too
  p_filter_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (filtEn && filtVal != '0 && polIn != filtOut && stableCnt == '0) |=> $stable(filtOut));
endmodule

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         modeCntDir,
  input  logic         phA,
  input  logic         phB,
  input  logic         clearCnt,
  input  logic         ovfClr,
  output qdec_strobe_t strobe
);
  logic       prevA;
  logic       prevB;
  logic       chgA;
  logic       chgB;
  logic       quadStep;
  logic       quadUp;
  logic       riseA;
  qdec_mode_e mode;

  assign mode = qdec_mode_e'(modeCntDir);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= phA;
      prevB <= phB;
    end
  end

  assign chgA     = phA ^ prevA;
  assign chgB     = phB ^ prevB;
  assign quadStep = chgA ^ chgB;
  assign quadUp   = phA ^ prevB;
  assign riseA    = phA & ~prevA;

  always_comb begin
    strobe        = '0;
    strobe.clear  = clearCnt;
    strobe.ovfClr = ovfClr;
    if (mode == MODE_QUAD) begin
      strobe.stepUp = quadStep & quadUp;
      strobe.stepDn = quadStep & ~quadUp;
    end else begin
      strobe.stepUp = riseA & phB;
      strobe.stepDn = riseA & ~phB;
    end
  end

  p_one_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.stepUp && strobe.stepDn));

  // R3: a double change in quadrature mode produces no step
  p_illegal_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_QUAD && chgA && chgB) |-> !(strobe.stepUp || strobe.stepDn));

  // R4: in pulse/direction mode a step needs a rising A
  p_cntdir_edge_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_CNTDIR && (strobe.stepUp || strobe.stepDn)) |-> (phA && !prevA));
endmodule

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qdec_strobe_t     strobe,
  input  logic [CNT_W-1:0] lowLimit,
  input  logic [CNT_W-1:0] highLimit,
  output logic [CNT_W-1:0] count,
  output logic             dirUp,
  output logic             ovfFlag,
  output logic             ovfAtTop
);
  logic atTop;
  logic atBottom;

  assign atTop    = count >= highLimit;
  assign atBottom = count <= lowLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      dirUp    <= 1'b0;
      ovfFlag  <= 1'b0;
      ovfAtTop <= 1'b0;
    end else begin
      if (strobe.ovfClr) ovfFlag <= 1'b0;
      if (strobe.clear) begin
        count <= lowLimit;
      end else if (strobe.stepUp) begin
        dirUp <= 1'b1;
        if (atTop) begin
          count    <= lowLimit;
          ovfFlag  <= 1'b1;
          ovfAtTop <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end else if (strobe.stepDn) begin
        dirUp <= 1'b0;
        if (atBottom) begin
          count    <= highLimit;
          ovfFlag  <= 1'b1;
          ovfAtTop <= 1'b0;
        end else begin
          count <= count - 1'b1;
        end
      end
    end
  end

  p_wrap_top_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.stepUp && count >= highLimit) |=>
      (count == $past(lowLimit) && ovfFlag && ovfAtTop));

  p_wrap_bottom_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.stepDn && count <= lowLimit) |=>
      (count == $past(highLimit) && ovfFlag && !ovfAtTop));

  p_dir_up_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.stepUp) |=> dirUp);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> count == $past(lowLimit));

  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !strobe.ovfClr) |=> ovfFlag);
endmodule

// File: rtl/qdec_position_counter.sv
module qdec_position_counter
  import qdec_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeCntDir,
  input  logic              phaseA,
  input  logic              phaseB,
  input  logic              invA,
  input  logic              invB,
  input  logic              filtEnA,
  input  logic              filtEnB,
  input  logic [FILT_W-1:0] filtValA,
  input  logic [FILT_W-1:0] filtValB,
  input  logic [CNT_W-1:0]  lowLimit,
  input  logic [CNT_W-1:0]  highLimit,
  input  logic              clearCnt,
  input  logic              ovfClr,
  output logic [CNT_W-1:0]  count,
  output logic              dirUp,
  output logic              ovfFlag,
  output logic              ovfAtTop
);
  localparam int N_PHASE = 2;

  logic [N_PHASE-1:0] rawPh;
  logic [N_PHASE-1:0] invPh;
  logic [N_PHASE-1:0] enPh;
  logic [N_PHASE-1:0] condPh;
  qdec_strobe_t       strobe;

  assign rawPh = {phaseB, phaseA};
  assign invPh = {invB, invA};
  assign enPh  = {filtEnB, filtEnA};

  for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
    qdec_phase_cond #(.FILT_W(FILT_W)) cond_i (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawPh[g]),
      .invert  (invPh[g]),
      .filtEn  (enPh[g]),
      .filtVal ((g == 0) ? filtValA : filtValB),
      .filtOut (condPh[g])
    );
  end

  qdec_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .modeCntDir (modeCntDir),
    .phA        (condPh[0]),
    .phB        (condPh[1]),
    .clearCnt   (clearCnt),
    .ovfClr     (ovfClr),
    .strobe     (strobe)
  );

  qdec_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lowLimit  (lowLimit),
    .highLimit (highLimit),
    .count     (count),
    .dirUp     (dirUp),
    .ovfFlag   (ovfFlag),
    .ovfAtTop  (ovfAtTop)
  );
endmodule

// File: tb/qdec_position_counter_tb.sv
module qdec_position_counter_tb_top;
  localparam int CNT_W  = 16;
  localparam int FILT_W = 4;
  localparam int NV     = 10;

  // quadrature table: phase A, phase B, expected count, expected direction
  localparam int VA [NV] = '{1, 1, 0, 0, 0, 1, 1, 0, 1, 0};
  localparam int VB [NV] = '{0, 1, 1, 0, 1, 1, 0, 0, 1, 0};
  localparam int VC [NV] = '{11, 12, 13, 14, 13, 12, 11, 10, 10, 10};
  localparam int VD [NV] = '{1, 1, 1, 1, 0, 0, 0, 0, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeCntDir = 1'b0;
  logic phaseA = 1'b0, phaseB = 1'b0, invA = 1'b0, invB = 1'b0;
  logic filtEnA = 1'b0, filtEnB = 1'b0;
  logic [FILT_W-1:0] filtValA = '0, filtValB = '0;
  logic [CNT_W-1:0] lowLimit = '0, highLimit = '0;
  logic clearCnt = 1'b0, ovfClr = 1'b0;
  logic [CNT_W-1:0] count;
  logic dirUp, ovfFlag, ovfAtTop;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  qdec_position_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W)) dut_i (
    .clk(clk), .rstN(rstN), .modeCntDir(modeCntDir), .phaseA(phaseA), .phaseB(phaseB),
    .invA(invA), .invB(invB), .filtEnA(filtEnA), .filtEnB(filtEnB),
    .filtValA(filtValA), .filtValB(filtValB), .lowLimit(lowLimit), .highLimit(highLimit),
    .clearCnt(clearCnt), .ovfClr(ovfClr), .count(count), .dirUp(dirUp),
    .ovfFlag(ovfFlag), .ovfAtTop(ovfAtTop)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic apply(input logic a, input logic b, input int n);
    @(negedge clk);
    phaseA = a;
    phaseB = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear();
    @(negedge clk); clearCnt = 1'b1;
    @(negedge clk); clearCnt = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovfClr = 1'b1;
    @(negedge clk); ovfClr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 count", int'(count), 0);
    check("R1 dirUp", int'(dirUp), 0);
    check("R1 ovfFlag", int'(ovfFlag), 0);
    check("R1 ovfAtTop", int'(ovfAtTop), 0);
    rstN = 1'b1;
    lowLimit = 10; highLimit = 20;
    repeat (4) @(negedge clk);
    pulse_clear();
    check("R10 clear to low", int'(count), 10);

    // table walk: forward cycle, reverse cycle, double changes (R2 R3 R9)
    for (int i = 0; i < NV; i++) begin
      apply(VA[i][0], VB[i][0], 6);
      check(i < 8 ? "R2 quad count" : "R3 illegal ignored", int'(count), VC[i]);
      check("R9 direction", int'(dirUp), VD[i]);
    end

    // top wrap in a narrow window (R7)
    highLimit = 12;
    apply(1, 0, 6);
    apply(1, 1, 6);
    check("R2 approach top", int'(count), 12);
    apply(0, 1, 6);
    check("R7 wrap top count", int'(count), 10);
    check("R7 ovfFlag", int'(ovfFlag), 1);
    check("R7 ovfAtTop", int'(ovfAtTop), 1);
    pulse_ovf_clr();
    check("R11 ovf cleared", int'(ovfFlag), 0);

    // bottom wrap (R8) and sticky flag (R11)
    apply(1, 1, 6);
    check("R8 wrap bottom count", int'(count), 12);
    check("R8 ovfFlag", int'(ovfFlag), 1);
    check("R8 ovfAtTop", int'(ovfAtTop), 0);
    apply(1, 0, 6);
    apply(0, 0, 6);
    check("R11 sticky count", int'(count), 10);
    check("R11 ovf sticky", int'(ovfFlag), 1);
    pulse_ovf_clr();

    // polarity inversion (R5)
    highLimit = 20;
    @(negedge clk); invA = 1'b1;
    repeat (6) @(negedge clk);
    check("R5 invert A counts up", int'(count), 11);
    @(negedge clk); invA = 1'b0;
    repeat (6) @(negedge clk);
    check("R5 uninvert A counts down", int'(count), 10);

    // pulse/direction mode (R4)
    modeCntDir = 1'b1;
    apply(0, 1, 6);
    check("R4 B change no count", int'(count), 10);
    apply(1, 1, 6);
    check("R4 rise A with B high", int'(count), 11);
    apply(0, 1, 6);
    check("R4 fall A no count", int'(count), 11);
    apply(0, 0, 6);
    apply(1, 0, 6);
    check("R4 rise A with B low", int'(count), 10);
    check("R9 direction down", int'(dirUp), 0);
    apply(0, 0, 6);

    // filter (R6): window of 6 clocks
    filtEnA = 1'b1; filtValA = 5;
    apply(0, 1, 4);
    apply(1, 1, 3);
    apply(0, 1, 12);
    check("R6 short pulse dropped", int'(count), 10);
    apply(1, 1, 14);
    check("R6 held level passes", int'(count), 11);

    // clear while away from low (R10)
    pulse_clear();
    check("R10 clear again", int'(count), 10);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule